// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block produces the register-number stream for one short-vector floating-point operation. A start pulse captures a destination index, two source indices, a precision select, an element-count field and a stride field. The block then decides whether the operation is pure scalar, mixed (vector destination and first source with a fixed scalar second source) or full vector. After that it presents one triple of indices per accepted handshake cycle until the element count is used up.

Register indices are 5 bits wide. Single-precision registers sit in banks of eight and double-precision registers in banks of four. Every index that advances moves forward by the step, but only its in-bank low bits change, so it wraps back to the start of its own bank and never crosses into a neighbouring one. Whether a bank counts as scalar depends on the precision, and the bank holding the destination and the bank holding the second source together decide the operation kind. The arithmetic, the register file and instruction decode are handled elsewhere. In a two-operand operation with a scalar source, the consumer reads that source once and writes the result to every destination index the block emits.

Top module: `short_vec_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it, `seq_valid` and `busy` are low.
- R2: An index is in a scalar bank when its bits [4:3] are zero (single precision, `dbl`=0) or when its bits [3:2] are zero (double precision, `dbl`=1). If the destination is in a scalar bank, `kind`=0 (scalar) and exactly one element is emitted, whatever `vec_len` holds.
- R3: If the destination is in a vector bank and the second source is in a scalar bank, `kind`=1 (mixed) and `idx_m` keeps its start value for every element.
- R4: If neither the destination nor the second source is in a scalar bank, `kind`=2 (vector) and all three indices advance on each element.
- R5: The step added per element is `stride`+1 in single precision and (`stride`>>1)+1 in double precision.
- R6: When an index advances, the step is added to its low 3 bits modulo 8 (single) or to its low 2 bits modulo 4 (double), and the bits above stay unchanged. For example, double index 6 advanced by 2 gives 4.
- R7: A vector or mixed operation emits `vec_len`+1 elements. `seq_last` is high together with the final element, and `seq_valid` is low in the cycle after that element is accepted.
- R8: While `seq_valid` is high and `seq_ready` is low, all outputs hold their values. The sequence advances only on a cycle where both are high.
- R9: A start pulse while `busy` is high is ignored, and the current sequence continues unchanged.
- R10: In double precision, indices 16 to 19 count as scalar in the same way as 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures the operation fields when the block is idle |
| dbl | input | 1 | Precision select: 0 single, 1 double |
| vec_len | input | 3 | Element count minus one |
| stride | input | 2 | Stride field |
| src_d | input | 5 | Destination start index |
| src_n | input | 5 | First source start index |
| src_m | input | 5 | Second source start index |
| seq_valid | output | 1 | An index triple is presented |
| seq_ready | input | 1 | Consumer accepts the presented triple |
| idx_d | output | 5 | Destination index |
| idx_n | output | 5 | First source index |
| idx_m | output | 5 | Second source index |
| kind | output | 2 | 0 scalar, 1 mixed, 2 vector |
| seq_last | output | 1 | The presented triple is the final one |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions take for granted that the consumer drives `seq_ready` as a plain level and that `start` in any cycle while `busy` is high is legal noise that must be discarded. They also rely on the index fields carrying only 5-bit values, so bank bits are always well defined. The stimulus covers both precisions, every stride and every length with start indices anywhere inside their banks, so wraps from mid-bank starts occur often. It drops `seq_ready` at random and injects stray start pulses with other fields during sequences, which keeps every handshake and ignore case within these assumptions.

// File: rtl/svseq_pkg.sv
package svseq_pkg;
    localparam int IDX_W     = 5;
    localparam int LEN_W     = 3;
    localparam int STRIDE_W  = 2;
    localparam int STEP_W    = STRIDE_W + 1;
    localparam int SGL_LOW   = 3;   // in-bank bits, single precision
    localparam int DBL_LOW   = 2;   // in-bank bits, double precision
    localparam int NUM_LANES = 3;   // destination, first source, second source

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [LEN_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        KIND_SCALAR = 2'd0,
        KIND_MIXED  = 2'd1,
        KIND_VECTOR = 2'd2
    } op_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        op_kind_e kind;
        step_t    step;
        cnt_t     remain;
    } plan_t;

    // Bank-based scalar test; the bank field sits just above the in-bank bits.
    function automatic logic in_scalar_bank(idx_t idx, logic is_dbl);
        if (is_dbl)
            return idx[DBL_LOW+1:DBL_LOW] == 2'b00;
        return idx[SGL_LOW+1:SGL_LOW] == 2'b00;
    endfunction

    function automatic step_t step_from(logic [STRIDE_W-1:0] strd, logic is_dbl);
        if (is_dbl)
            return step_t'(strd >> 1) + step_t'(1);
        return step_t'(strd) + step_t'(1);
    endfunction
endpackage

// File: rtl/svseq_classify.sv
module svseq_classify
    import svseq_pkg::*;
(
    input  logic                is_dbl,
    input  cnt_t                len,
    input  logic [STRIDE_W-1:0] strd,
    input  idx_t                dst,
    input  idx_t                src2,
    output plan_t               plan
);
    logic dst_scalar;
    logic src2_scalar;

    always_comb begin
        dst_scalar  = in_scalar_bank(dst, is_dbl);
        src2_scalar = in_scalar_bank(src2, is_dbl);
        plan.step   = step_from(strd, is_dbl);
        if (dst_scalar) begin
            plan.kind   = KIND_SCALAR;
            plan.remain = '0;
        end else begin
            plan.kind   = src2_scalar ? KIND_MIXED : KIND_VECTOR;
            plan.remain = len;
        end
    end
endmodule

// File: rtl/svseq_advance.sv
module svseq_advance
    import svseq_pkg::*;
(
    input  idx_t  cur,
    input  step_t step,
    input  logic  is_dbl,
    input  logic  en,
    output idx_t  nxt
);
    localparam int SUM_W = (STEP_W > SGL_LOW ? STEP_W : SGL_LOW) + 1;

    logic [SUM_W-1:0] sum_s;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_s = SUM_W'(cur[SGL_LOW-1:0]) + SUM_W'(step);
        sum_d = SUM_W'(cur[DBL_LOW-1:0]) + SUM_W'(step);
        nxt   = cur;
        if (en) begin
            if (is_dbl)
                nxt[DBL_LOW-1:0] = sum_d[DBL_LOW-1:0];
            else
                nxt[SGL_LOW-1:0] = sum_s[SGL_LOW-1:0];
        end
    end
endmodule

// File: rtl/svseq_ctrl.sv
module svseq_ctrl
    import svseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  cnt_t  remain_init,
    input  logic  fire_out,
    output logic  load,
    output logic  step_en,
    output logic  valid,
    output logic  last
);
    seq_state_e state_q;
    cnt_t       remain_q;

    assign load    = (state_q == ST_IDLE) && start;
    assign valid   = (state_q == ST_RUN);
    assign last    = valid && (remain_q == '0);
    assign step_en = fire_out && !last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else if (load) begin
            state_q  <= ST_RUN;
            remain_q <= remain_init;
        end else if (fire_out) begin
            if (last)
                state_q <= ST_IDLE;
            else
                remain_q <= remain_q - cnt_t'(1);
        end
    end
endmodule

// File: rtl/short_vec_seq.sv
module short_vec_seq
    import svseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dbl,
    input  logic [LEN_W-1:0]    vec_len,
    input  logic [STRIDE_W-1:0] stride,
    input  logic [IDX_W-1:0]    src_d,
    input  logic [IDX_W-1:0]    src_n,
    input  logic [IDX_W-1:0]    src_m,
    output logic                seq_valid,
    input  logic                seq_ready,
    output logic [IDX_W-1:0]    idx_d,
    output logic [IDX_W-1:0]    idx_n,
    output logic [IDX_W-1:0]    idx_m,
    output logic [1:0]          kind,
    output logic                seq_last,
    output logic                busy
);
    plan_t plan_in;
    plan_t plan_q;
    logic  dbl_q;
    logic  load;
    logic  step_en;
    logic  fire_out;
    idx_t  lane_q   [NUM_LANES];
    idx_t  lane_nxt [NUM_LANES];
    idx_t  lane_src [NUM_LANES];

    assign lane_src[0] = src_d;
    assign lane_src[1] = src_n;
    assign lane_src[2] = src_m;

    svseq_classify u_classify (
        .is_dbl (dbl),
        .len    (vec_len),
        .strd   (stride),
        .dst    (src_d),
        .src2   (src_m),
        .plan   (plan_in)
    );

    assign fire_out = seq_valid && seq_ready;

    svseq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .remain_init (plan_in.remain),
        .fire_out    (fire_out),
        .load        (load),
        .step_en     (step_en),
        .valid       (seq_valid),
        .last        (seq_last)
    );

    // One advance unit per lane; the second source moves only in vector mode.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic lane_en;
        if (g == NUM_LANES - 1) begin : g_src2
            assign lane_en = (plan_q.kind == KIND_VECTOR);
        end else begin : g_main
            assign lane_en = 1'b1;
        end

        svseq_advance u_adv (
            .cur    (lane_q[g]),
            .step   (plan_q.step),
            .is_dbl (dbl_q),
            .en     (lane_en),
            .nxt    (lane_nxt[g])
        );

        always_ff @(posedge clk) begin
            if (rst)
                lane_q[g] <= '0;
            else if (load)
                lane_q[g] <= lane_src[g];
            else if (step_en)
                lane_q[g] <= lane_nxt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q <= '{kind: KIND_SCALAR, step: '0, remain: '0};
            dbl_q  <= 1'b0;
        end else if (load) begin
            plan_q <= plan_in;
            dbl_q  <= dbl;
        end
    end

    assign idx_d = lane_q[0];
    assign idx_n = lane_q[1];
    assign idx_m = lane_q[2];
    assign kind  = plan_q.kind;
    assign busy  = seq_valid;
endmodule

// File: rtl/svseq_checker.sv
module svseq_checker
    import svseq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             seq_valid,
    input logic             seq_ready,
    input logic [IDX_W-1:0] idx_d,
    input logic [IDX_W-1:0] idx_n,
    input logic [IDX_W-1:0] idx_m,
    input logic [1:0]       kind,
    input logic             seq_last,
    input logic             busy
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && !seq_ready) |=> (seq_valid && $stable(idx_d) && $stable(idx_n)
                                       && $stable(idx_m) && $stable(kind) && $stable(seq_last)));

    assert_src2_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && seq_ready && !seq_last && kind == 2'd1) |=> $stable(idx_m));

    assert_scalar_single_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && kind == 2'd0) |-> seq_last);

    assert_bank_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && seq_ready && !seq_last) |=> ($stable(idx_d[IDX_W-1:SGL_LOW])
                                                   && $stable(idx_n[IDX_W-1:SGL_LOW])));

    assert_end_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_valid && seq_ready && seq_last && !start) |=> !seq_valid);

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !(seq_ready && seq_last)) |=> ($stable(kind) && seq_valid));
endmodule

bind short_vec_seq svseq_checker u_svseq_checker (.*);

// File: tb/test_short_vec_seq.sv
module test_short_vec_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       dbl;
    logic [2:0] vec_len;
    logic [1:0] stride;
    logic [4:0] src_d, src_n, src_m;
    logic       seq_valid, seq_ready;
    logic [4:0] idx_d, idx_n, idx_m;
    logic [1:0] kind;
    logic       seq_last, busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    short_vec_seq i_short_vec_seq (.*);

    function automatic bit scal(logic [4:0] r, logic d);
        return d ? (r[3:2] == 2'b00) : (r[4:3] == 2'b00);
    endfunction

    function automatic logic [4:0] adv(logic [4:0] r, int st, logic d);
        if (d) return {r[4:2], 2'((r[1:0] + st) % 4)};
        return {r[4:3], 3'((r[2:0] + st) % 8)};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one operation; noisy adds random ready drops and stray starts.
    task automatic run_op(logic d, logic [2:0] ln, logic [1:0] sd,
                          logic [4:0] rd, logic [4:0] rn, logic [4:0] rm, bit noisy);
        int n, st, k, e, guard;
        logic [4:0] ed, en, em;
        st = d ? (sd >> 1) + 1 : sd + 1;                        // R5
        if (scal(rd, d)) begin n = 1; k = 0; end                // R2, R10
        else begin n = ln + 1; k = scal(rm, d) ? 1 : 2; end     // R3, R4, R7
        @(negedge clk);
        dbl = d; vec_len = ln; stride = sd; src_d = rd; src_n = rn; src_m = rm;
        start = 1'b1; seq_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        ed = rd; en = rn; em = rm; e = 0; guard = 0;
        while (e < n && guard < 200) begin
            guard++;
            chk(seq_valid === 1'b1, "R7 valid", int'(seq_valid), 1);
            chk(idx_d === ed, "R6 idx_d", int'(idx_d), int'(ed));
            chk(idx_n === en, "R6 idx_n", int'(idx_n), int'(en));
            chk(idx_m === em, "R3 idx_m", int'(idx_m), int'(em));
            chk(kind === 2'(k), "R2 kind", int'(kind), k);
            chk(seq_last === (e == n - 1), "R7 last", int'(seq_last), int'(e == n - 1));
            seq_ready = noisy ? ($urandom % 3 != 0) : 1'b1;
            if (noisy && ($urandom % 4 == 0) && !(seq_ready && e == n - 1)) begin
                start = 1'b1;                                   // R9 stray start
                src_d = 5'($urandom); src_m = 5'($urandom); dbl = 1'($urandom);
            end
            @(negedge clk);
            start = 1'b0;
            if (seq_ready) begin
                e++;
                ed = adv(ed, st, d); en = adv(en, st, d);
                if (k == 2) em = adv(em, st, d);
            end
        end
        seq_ready = 1'b0;
        chk(e == n, "R8 progress", e, n);
        chk(seq_valid === 1'b0 && busy === 1'b0, "R7 end", int'(seq_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; start = 1'b0; dbl = 1'b0; vec_len = '0; stride = '0;
        src_d = '0; src_n = '0; src_m = '0; seq_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(seq_valid === 1'b0 && busy === 1'b0, "R1 reset", int'(seq_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(seq_valid === 1'b0, "R1 after reset", int'(seq_valid), 0);

        run_op(1'b1, 3'd3, 2'd2, 5'd6, 5'd9, 5'd10, 1'b0);  // R6: d6+2 -> d4
        run_op(1'b0, 3'd7, 2'd3, 5'd13, 5'd22, 5'd3, 1'b0); // R3 mixed, single wrap
        run_op(1'b0, 3'd7, 2'd0, 5'd2, 5'd9, 5'd17, 1'b0);  // R2 scalar dest
        run_op(1'b1, 3'd5, 2'd1, 5'd18, 5'd4, 5'd8, 1'b0);  // R10 d18 scalar
        run_op(1'b1, 3'd4, 2'd0, 5'd7, 5'd21, 5'd17, 1'b0); // R10 mixed with d17
        run_op(1'b0, 3'd0, 2'd1, 5'd31, 5'd8, 5'd24, 1'b0); // R4 one element
        run_op(1'b0, 3'd5, 2'd1, 5'd30, 5'd14, 5'd25, 1'b1);// R8, R9 noisy

        for (int i = 0; i < 150; i++) begin
            run_op(1'($urandom), 3'($urandom), 2'($urandom),
                   5'($urandom), 5'($urandom), 5'($urandom), 1'b1);
        end

        // R1: reset in the middle of a sequence
        @(negedge clk);
        dbl = 1'b0; vec_len = 3'd7; stride = 2'd0; src_d = 5'd9; src_n = 5'd9; src_m = 5'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(seq_valid === 1'b0, "R1 mid reset", int'(seq_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(seq_valid === 1'b0 && busy === 1'b0, "R1 idle", int'(seq_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule